// File: doc/BRIEF.md
# Byte-Wide SPI Port with Selectable Chip-Select and Overflow Policy

This block is a one-byte-deep serial peripheral port for a small microcontroller. With `master` high it drives the serial clock from the core clock through a selectable divider. It shifts out the byte held in its transmit register and captures the reply. With `master` low it follows a clock driven by an external controller. In that mode an active-low select input can be used to gate it, or the select can be ignored. The clock idles low. Data moves most significant bit first. Outgoing bits change after falling clock edges, and incoming bits are sampled on rising edges.

One 8-bit mode register sets the behaviour. It chooses which event drives the interrupt line and whether chip-select is automatic or held low for software control. It also enables the slave-select input, decides what happens to a byte that arrives while the previous one is unread, and picks the master clock rate. In automatic mode a lone byte gets its own select pulse. If a new byte is written before the current one finishes, the transfers join into one burst: there is no gap between bytes and select stays low for the whole burst.

Top module: `spi_byte_port`

## Requirements
- R1: After reset the mode register reads 0x10. Mode bits are: [5] interrupt on transmit-empty, [4] automatic chip-select, [3] slave-select input enable, [2] overwrite on overflow, [1:0] rate code. Bits 7:6 always read 0 whatever was written.
- R2: In master mode, consecutive rising edges of `sclk_o` are 8, 16, 32 or 64 core cycles apart for rate codes 0, 1, 2 and 3. `sclk_o` is low whenever no transfer runs.
- R3: Bits go out on `sdo` most significant first, stable at each rising edge of `sclk_o`. The byte sampled from `sdi` on the eight rising edges (first bit as MSB) appears on `rx_rdata`.
- R4: While mode bit 4 is 0, `ss_o` is low at all times, idle or transferring.
- R5: While mode bit 4 is 1, `ss_o` goes low for a lone byte transfer. It returns high at the final falling clock edge of that byte.
- R6: A transmit write made while a byte is shifting forms a burst. The next byte starts with no gap (rising edges stay evenly spaced), and `ss_o` stays low until the last byte ends.
- R7: `tx_empty` drops on a transmit write. It rises again when the byte is moved into the shift register.
- R8: `rx_full` rises when a byte is completed. Pulsing `rx_rd` clears it.
- R9: With mode bit 2 at 0, a byte that completes while `rx_full` is high is dropped, and `rx_rdata` keeps the old byte.
- R10: With mode bit 2 at 1, such a byte replaces the old one in `rx_rdata`.
- R11: `ovf_flag` is set by any byte that completes while `rx_full` is high, under either policy. It stays set until `ovf_clr` is pulsed.
- R12: `irq` follows `rx_full` when mode bit 5 is 0, and follows `tx_empty` when it is 1.
- R13: In slave mode with mode bit 3 set, clock edges on `sclk_i` are ignored while `ss_i` is high. When the bit is clear, `ss_i` is ignored. A selected slave receives MSB first from `sdi` and returns its transmit byte MSB first on `sdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master | input | 1 | 1 = generate the clock, 0 = follow `sclk_i` |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write value |
| cfg_rdata | output | 8 | Mode register contents |
| tx_wr | input | 1 | Transmit register write strobe |
| tx_wdata | input | 8 | Byte to send |
| tx_empty | output | 1 | Transmit register free |
| rx_rd | input | 1 | Receive register read strobe |
| rx_rdata | output | 8 | Last accepted received byte |
| rx_full | output | 1 | Receive register holds an unread byte |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky overflow indication |
| irq | output | 1 | Interrupt request, level |
| sclk_o | output | 1 | Serial clock out (master) |
| ss_o | output | 1 | Chip-select out, active low |
| sdo | output | 1 | Serial data out |
| sclk_i | input | 1 | Serial clock in (slave) |
| ss_i | input | 1 | Slave-select in, active low |
| sdi | input | 1 | Serial data in |

## Verification
The hardest condition to reach is a burst: a second byte must reach the transmit register while the first is still shifting. Only then can the block chain bytes, hold select low and deliver a byte into a still-full receive register. The bench issues the second write a few clock edges into the first byte. It then times every rising edge across the byte boundary and leaves the first received byte unread, so one burst checks the gapless join, the select hold and both overflow policies. Slave selection is reached by clocking a full byte with the select input high, then repeating it with the select low.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef struct packed {
    logic [1:0] rsvd;
    logic       irq_on_tx;
    logic       auto_cs;
    logic       cs_in_en;
    logic       rx_replace;
    logic [1:0] rate;
  } spi_mode_t;

  localparam logic [7:0] MODE_RESET = 8'h10;

  // core cycles per half period of the master clock
  function automatic int unsigned sclk_half(input logic [1:0] rate, input int unsigned base_div);
    return (base_div / 2) << rate;
  endfunction

  // written mode value with the reserved field forced to zero
  function automatic logic [7:0] mode_clean(input logic [7:0] v);
    return {2'b00, v[5:0]};
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_port_pkg::*;
#(
  parameter int BASE_DIV = 8,
  parameter int CW       = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       sclk,
  output logic       rise,
  output logic       fall
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          tick;

  assign limit = CW'(sclk_half(rate, BASE_DIV) - 1);
  assign tick  = run && (cnt >= limit);
  assign rise  = tick && !sclk;
  assign fall  = tick && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= !sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic          m_rise,
  input  logic          m_fall,
  input  logic          m_sdi,
  input  logic          s_sclk,
  input  logic          s_sdi,
  input  logic          s_sel,
  input  logic [DW-1:0] tx_buf,
  input  logic          tx_pending,
  output logic          sdo,
  output logic          busy,
  output logic          load_evt,
  output logic          byte_done,
  output logic [DW-1:0] rx_byte
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST  = CW'(DW);
  localparam logic [CW-1:0] SLAST = CW'(DW - 1);

  logic [DW-1:0] shreg, rxsh;
  logic [CW-1:0] bitcnt;
  logic          s_sclk_d;
  logic          s_rise, s_fall, m_start, m_end, m_chain, s_done, s_load;

  assign s_rise  = s_sclk && !s_sclk_d;
  assign s_fall  = !s_sclk && s_sclk_d;
  assign m_start = master && !busy && tx_pending;
  assign m_end   = master && busy && m_fall && (bitcnt == LAST);
  assign m_chain = m_end && tx_pending;
  assign s_done  = !master && s_sel && s_rise && (bitcnt == SLAST);
  assign s_load  = !master && s_sel && (bitcnt == '0) && tx_pending && !s_rise && !s_fall;

  assign load_evt  = m_start || m_chain || s_load;
  assign byte_done = m_end || s_done;
  assign rx_byte   = master ? rxsh : {rxsh[DW-2:0], s_sdi};
  assign sdo       = shreg[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      rxsh     <= '0;
      bitcnt   <= '0;
      busy     <= 1'b0;
      s_sclk_d <= 1'b0;
    end else begin
      s_sclk_d <= s_sclk;
      if (master) begin
        if (m_start) begin
          shreg  <= tx_buf;
          bitcnt <= '0;
          busy   <= 1'b1;
        end else if (busy && m_rise) begin
          rxsh   <= {rxsh[DW-2:0], m_sdi};
          bitcnt <= bitcnt + 1'b1;
        end else if (busy && m_fall) begin
          if (bitcnt == LAST) begin
            bitcnt <= '0;
            if (tx_pending) shreg <= tx_buf;
            else            busy  <= 1'b0;
          end else begin
            shreg <= shreg << 1;
          end
        end
      end else begin
        busy <= 1'b0;
        if (!s_sel) begin
          bitcnt <= '0;
        end else if (s_rise) begin
          rxsh   <= {rxsh[DW-2:0], s_sdi};
          bitcnt <= s_done ? '0 : bitcnt + 1'b1;
        end else if (s_fall) begin
          if (bitcnt != '0) shreg <= shreg << 1;
        end else if (s_load) begin
          shreg <= tx_buf;
        end
      end
    end
  end
endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
  import spi_port_pkg::*;
#(
  parameter int BASE_DIV    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       master,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       tx_wr,
  input  logic [7:0] tx_wdata,
  output logic       tx_empty,
  input  logic       rx_rd,
  output logic [7:0] rx_rdata,
  output logic       rx_full,
  input  logic       ovf_clr,
  output logic       ovf_flag,
  output logic       irq,
  output logic       sclk_o,
  output logic       ss_o,
  output logic       sdo,
  input  logic       sclk_i,
  input  logic       ss_i,
  input  logic       sdi
);
  localparam int DW    = 8;
  localparam int DIV_W = $clog2(BASE_DIV * 8);

  spi_mode_t     mode_q;
  logic [DW-1:0] tx_buf;
  logic          busy, load_evt, byte_done, rx_clash, s_sel;
  logic          m_rise, m_fall;
  logic [DW-1:0] rx_byte;
  logic [2:0]    pin_sync;

  // mode register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= spi_mode_t'(MODE_RESET);
    else if (cfg_wr) mode_q <= spi_mode_t'(mode_clean(cfg_wdata));
  end
  assign cfg_rdata = mode_q;

  // transmit holding register: a write wins over a same-cycle load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf   <= '0;
      tx_empty <= 1'b1;
    end else if (tx_wr) begin
      tx_buf   <= tx_wdata;
      tx_empty <= 1'b0;
    end else if (load_evt) begin
      tx_empty <= 1'b1;
    end
  end

  // receive holding register and overflow policy
  assign rx_clash = byte_done && rx_full && !rx_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rdata <= '0;
      rx_full  <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (byte_done && !rx_clash) begin
        rx_rdata <= rx_byte;
        rx_full  <= 1'b1;
      end else if (rx_clash) begin
        if (mode_q.rx_replace) rx_rdata <= rx_byte;
      end else if (rx_rd) begin
        rx_full <= 1'b0;
      end
      if (rx_clash)     ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
    end
  end

  // slave pins: {ss, sclk, data}
  spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ss_i, sclk_i, sdi}),
    .q     (pin_sync)
  );
  assign s_sel = !mode_q.cs_in_en || !pin_sync[2];

  spi_sclk_gen #(.BASE_DIV(BASE_DIV), .CW(DIV_W)) u_gen (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (master && busy),
    .rate  (mode_q.rate),
    .sclk  (sclk_o),
    .rise  (m_rise),
    .fall  (m_fall)
  );

  spi_shift_core #(.DW(DW)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .master     (master),
    .m_rise     (m_rise),
    .m_fall     (m_fall),
    .m_sdi      (sdi),
    .s_sclk     (pin_sync[1]),
    .s_sdi      (pin_sync[0]),
    .s_sel      (s_sel),
    .tx_buf     (tx_buf),
    .tx_pending (!tx_empty),
    .sdo        (sdo),
    .busy       (busy),
    .load_evt   (load_evt),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte)
  );

  assign irq  = mode_q.irq_on_tx ? tx_empty : rx_full;
  assign ss_o = mode_q.auto_cs ? !(master && busy) : 1'b0;
endmodule

// File: rtl/spi_byte_port_chk.sv
module spi_byte_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       master,
  input logic [7:0] mode,
  input logic       cfg_wr,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cfg_rdata,
  input logic       busy,
  input logic       sclk_o,
  input logic       ss_o,
  input logic       load_evt,
  input logic       tx_wr,
  input logic       tx_empty,
  input logic       byte_done,
  input logic       rx_clash,
  input logic       rx_rd,
  input logic       rx_full,
  input logic [7:0] rx_rdata,
  input logic [7:0] rx_byte,
  input logic       ovf_flag
);
  assert_cfg_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_rdata == {2'b00, $past(cfg_wdata[5:0])});

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk_o);

  assert_manual_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[4] |-> !ss_o);

  assert_burst_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    master && busy && byte_done && !tx_empty |=> busy);

  assert_load_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && !tx_wr |=> tx_empty);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd && !byte_done |=> !rx_full);

  assert_drop_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clash && !mode[2] |=> $stable(rx_rdata));

  assert_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clash && mode[2] |=> rx_rdata == $past(rx_byte));

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clash |=> ovf_flag);
endmodule

bind spi_byte_port spi_byte_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .master    (master),
  .mode      (mode_q),
  .cfg_wr    (cfg_wr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .busy      (busy),
  .sclk_o    (sclk_o),
  .ss_o      (ss_o),
  .load_evt  (load_evt),
  .tx_wr     (tx_wr),
  .tx_empty  (tx_empty),
  .byte_done (byte_done),
  .rx_clash  (rx_clash),
  .rx_rd     (rx_rd),
  .rx_full   (rx_full),
  .rx_rdata  (rx_rdata),
  .rx_byte   (rx_byte),
  .ovf_flag  (ovf_flag)
);

// File: tb/sim_spi_byte_port.sv
module sim_spi_byte_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master = 1'b1;
  logic cfg_wr = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0, ovf_clr = 1'b0;
  logic [7:0] cfg_wdata = '0, tx_wdata = '0;
  logic sclk_i = 1'b0, ss_i = 1'b1, sdi = 1'b0;
  logic [7:0] cfg_rdata, rx_rdata;
  logic tx_empty, rx_full, ovf_flag, irq, sclk_o, ss_o, sdo;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_byte_port u0 (
    .clk(clk), .rst_n(rst_n), .master(master),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_empty(tx_empty),
    .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_full(rx_full),
    .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .irq(irq),
    .sclk_o(sclk_o), .ss_o(ss_o), .sdo(sdo),
    .sclk_i(sclk_i), .ss_i(ss_i), .sdi(sdi)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic tx_write(input logic [7:0] v);
    @(negedge clk); tx_wr = 1'b1; tx_wdata = v;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic rx_read();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
    check(rx_full === 1'b0, "R8 rx_full after read", int'(rx_full), 0);
  endtask

  task automatic pulse_ovf_clr();
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    check(ovf_flag === 1'b0, "R11 ovf_flag after clear", int'(ovf_flag), 0);
  endtask

  // master transfer of one or two bytes; the bench plays the far device on sdi
  task automatic master_run(input logic [7:0] t0, input logic [7:0] t1,
                            input logic [7:0] r0, input logic [7:0] r1,
                            input int nb, input int rate, input bit autocs);
    logic [15:0] tv;
    logic [15:0] rv;
    int last_rise;
    tv = {t0, t1};
    rv = {r0, r1};
    last_rise = 0;
    sdi = r0[7];
    tx_write(t0);
    check(tx_empty === 1'b0, "R7 tx_empty cleared by write", int'(tx_empty), 0);
    @(negedge clk);
    check(tx_empty === 1'b1, "R7 tx_empty set on load", int'(tx_empty), 1);
    for (int k = 0; k < 8 * nb; k++) begin
      while (sclk_o !== 1'b1) @(negedge clk);
      check(sdo === tv[15-k], "R3 sdo bit at rising edge", int'(sdo), int'(tv[15-k]));
      if (k > 0)
        check(cyc - last_rise == (8 << rate), "R2 R6 rising edge spacing",
              cyc - last_rise, 8 << rate);
      check(ss_o === 1'b0, autocs ? "R5 R6 ss_o low in transfer" : "R4 ss_o low in transfer",
            int'(ss_o), 0);
      last_rise = cyc;
      if (nb == 2 && k == 2) tx_write(t1);
      while (sclk_o !== 1'b0) @(negedge clk);
      if (k < 8 * nb - 1) sdi = rv[14-k];
    end
    check(ss_o === (autocs ? 1'b1 : 1'b0), autocs ? "R5 ss_o high after byte" : "R4 ss_o low after byte",
          int'(ss_o), autocs ? 1 : 0);
    repeat (3) @(negedge clk);
    check(sclk_o === 1'b0, "R2 sclk idle low", int'(sclk_o), 0);
  endtask

  // bench acts as the controller driving the slave pins
  task automatic slave_byte(input logic [7:0] din, output logic [7:0] dout);
    for (int i = 0; i < 8; i++) begin
      sdi = din[7-i];
      repeat (8) @(negedge clk);
      dout[7-i] = sdo;
      sclk_i = 1'b1;
      repeat (8) @(negedge clk);
      sclk_i = 1'b0;
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] got;
    logic [7:0] pats [4];
    pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'h01; pats[3] = 8'hFE;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_rdata === 8'h10, "R1 mode reset value", int'(cfg_rdata), 'h10);
    check(tx_empty === 1'b1 && rx_full === 1'b0 && ovf_flag === 1'b0,
          "R7 R8 R11 flags at reset", int'({tx_empty, rx_full, ovf_flag}), 'b100);
    check(ss_o === 1'b1 && sclk_o === 1'b0, "R5 R2 pins idle at reset", int'({ss_o, sclk_o}), 'b10);
    check(irq === 1'b0, "R12 irq at reset", int'(irq), 0);

    cfg_write(8'hFF);
    check(cfg_rdata === 8'h3F, "R1 reserved bits read zero", int'(cfg_rdata), 'h3F);

    // sweep rates and byte patterns, single bytes with automatic select
    for (int r = 0; r < 4; r++) begin
      for (int p = 0; p < 4; p++) begin
        cfg_write(8'h10 | 8'(r));
        master_run(pats[p], 8'h00, pats[p] ^ 8'h5A ^ 8'(r), 8'h00, 1, r, 1'b1);
        check(rx_full === 1'b1, "R8 rx_full after byte", int'(rx_full), 1);
        check(rx_rdata === (pats[p] ^ 8'h5A ^ 8'(r)), "R3 received byte",
              int'(rx_rdata), int'(pats[p] ^ 8'h5A ^ 8'(r)));
        check(irq === 1'b1, "R12 irq follows rx_full", int'(irq), 1);
        rx_read();
        check(irq === 1'b0, "R12 irq drops with rx_full", int'(irq), 0);
      end
    end

    // burst, drop policy
    cfg_write(8'h10);
    master_run(8'h96, 8'h69, 8'h11, 8'h22, 2, 0, 1'b1);
    check(rx_rdata === 8'h11, "R9 old byte kept", int'(rx_rdata), 'h11);
    check(ovf_flag === 1'b1, "R11 overflow set on drop", int'(ovf_flag), 1);
    pulse_ovf_clr();
    rx_read();

    // burst, overwrite policy
    cfg_write(8'h15);
    master_run(8'hC3, 8'h5A, 8'h33, 8'h44, 2, 1, 1'b1);
    check(rx_rdata === 8'h44, "R10 new byte replaces", int'(rx_rdata), 'h44);
    check(ovf_flag === 1'b1, "R11 overflow set on overwrite", int'(ovf_flag), 1);
    pulse_ovf_clr();
    rx_read();

    // manual chip-select
    cfg_write(8'h00);
    check(ss_o === 1'b0, "R4 ss_o low when idle", int'(ss_o), 0);
    master_run(8'h81, 8'h00, 8'h7E, 8'h00, 1, 0, 1'b0);
    check(rx_rdata === 8'h7E, "R3 received byte manual select", int'(rx_rdata), 'h7E);
    rx_read();

    // slave mode, select input enabled, interrupt on transmit-empty
    master = 1'b0;
    ss_i = 1'b1;
    cfg_write(8'h38);
    check(irq === 1'b1, "R12 irq follows tx_empty", int'(irq), 1);
    tx_write(8'h5B);
    repeat (4) @(negedge clk);
    check(tx_empty === 1'b0 && irq === 1'b0, "R12 R7 pending byte held while deselected",
          int'({tx_empty, irq}), 0);
    slave_byte(8'hE7, got);
    check(rx_full === 1'b0, "R13 deselected slave ignores clock", int'(rx_full), 0);
    ss_i = 1'b0;
    repeat (8) @(negedge clk);
    check(tx_empty === 1'b1 && irq === 1'b1, "R7 R12 load on select", int'({tx_empty, irq}), 'b11);
    slave_byte(8'h2D, got);
    check(got === 8'h5B, "R13 slave transmit byte", int'(got), 'h5B);
    check(rx_full === 1'b1 && rx_rdata === 8'h2D, "R13 selected slave receives",
          int'(rx_rdata), 'h2D);
    rx_read();

    // slave mode, select input disabled: ss_i high has no effect
    ss_i = 1'b1;
    cfg_write(8'h10);
    slave_byte(8'hB4, got);
    check(rx_full === 1'b1 && rx_rdata === 8'hB4, "R13 ss_i ignored when disabled",
          int'(rx_rdata), 'hB4);
    check(ss_o === 1'b1, "R5 ss_o high in slave mode", int'(ss_o), 1);
    rx_read();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule